// File: doc/BRIEF.md
# Deserializing Input Port with Timed Alignment

This block is the receive side of a clocked parallel input port. On every port-clock tick it takes `PIN_W` bits from the pins and shifts them into a staging register. Once `BUF_W` bits have built up, the staged word moves into a holding register that a consumer reads through a strobe. A data-ready flag announces each new word. A free-running 16-bit tick counter stamps every sample.

Word boundaries can be forced to line up with an external framing event in two ways. The first is a clear command, which throws away a partly built word. The second is a timed request, which names the counter value at which the next delivered word must end. A pattern-match capture records the counter value of the first tick on which the pins equal a given pattern. Software can then compute the alignment time from that stamp. `BUF_W` is 8 or 32, and `PIN_W` divides `BUF_W`. `BEATS = BUF_W/PIN_W` ticks make one word.

Top module: `dser_port`

## Requirements
- R1: After reset, `word_rdy`, `ovf`, `pm_hit`, `ptime` and `rd_data` are all zero.
- R2: Each tick shifts `PIN_W` pin bits in, first sample least significant. Sample k of a word (k = 0 first) lands at bits `[k*PIN_W +: PIN_W]`. On the tick that completes the word, the word appears on `rd_data` and `word_rdy` rises, both visible after that clock edge.
- R3: `rd_data` holds the last delivered word and does not change on ticks that do not complete a word.
- R4: A `rd` pulse while `word_rdy` is high lowers `word_rdy`. If a new word arrives in the same cycle as `rd`, `word_rdy` stays high, shows the new word, and `ovf` is not set.
- R5: If a word arrives while `word_rdy` is high and there is no `rd`, the older word is replaced and `ovf` is set. `ovf` stays set until a clear.
- R6: `ptime` rises by one on each tick, wraps from 0xFFFF to 0, and holds in cycles without a tick.
- R7: A `clr_buf` pulse empties the partial word and clears `ovf`. A tick in the same cycle is dropped, although it still advances `ptime`. The next word is built from the `BEATS` ticks that follow.
- R8: Once `at_arm` is pulsed with time T, no word is delivered until the tick whose stamp equals T. That word holds the samples stamped T-BEATS+1 through T. Later words complete every `BEATS` ticks after T. A tick's stamp is the `ptime` value before that tick.
- R9: Once `pm_arm` is pulsed, the first tick whose pins equal `pm_pat` sets `pm_hit` and copies that tick's stamp into `pm_time`. Later ticks leave `pm_time` alone. A new `pm_arm` lowers `pm_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Port-clock tick enable |
| pins | input | PIN_W | Pin sample |
| rd | input | 1 | Read strobe for the holding register |
| clr_buf | input | 1 | Flush the partial word and clear overrun |
| at_arm | input | 1 | Arm a timed word boundary |
| at_time | input | 16 | Stamp at which the aligned word ends |
| pm_arm | input | 1 | Arm the pin-match capture |
| pm_pat | input | PIN_W | Pin pattern to match |
| rd_data | output | BUF_W | Holding register |
| word_rdy | output | 1 | Unread word present |
| ovf | output | 1 | Sticky overrun |
| ptime | output | 16 | Free-running tick counter |
| pm_hit | output | 1 | Match captured |
| pm_time | output | 16 | Stamp of the matching tick |

## Verification
The bench goes after these corner cases and the failure each one exposes:
- **Bit order.** Mixed sample patterns catch a design that shifts toward the wrong end. Such a design would deliver the samples in reversed order.
- **Read in the same cycle as a new word.** This catches a design that lets the read win. That design would drop `word_rdy` even though a fresh word is waiting, or would flag a false overrun.
- **Clear on the same tick as a sample.** This catches a design that keeps the sample taken in the clear cycle. Its next word would complete one tick early.
- **Timed alignment.** A boundary is armed while the fill count is mid-word. A design that did not suppress the natural boundary would deliver a word early. A design off by one in the stamp would deliver a word shifted by one sample.
- **Match capture and counter wrap.** These catch a stamp taken after the increment and a counter that saturates instead of wrapping.

// File: rtl/dser_pkg.sv
package dser_pkg;
  localparam int TIME_W = 16;
  typedef logic [TIME_W-1:0] ptime_t;

  // ticks per delivered word
  function automatic int beats_per_word(input int buf_w, input int pin_w);
    return buf_w / pin_w;
  endfunction

  // counter advance with natural wrap
  function automatic ptime_t time_step(input ptime_t t);
    return t + ptime_t'(1);
  endfunction
endpackage

// File: rtl/dser_timebase.sv
module dser_timebase
  import dser_pkg::*;
#(
  parameter int PIN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PIN_W-1:0] pins,
  input  logic             pm_arm,
  input  logic [PIN_W-1:0] pm_pat,
  output ptime_t           stamp,
  output logic             pm_hit,
  output ptime_t           pm_time
);
  ptime_t           cnt_q;
  logic             m_armed_q;
  logic [PIN_W-1:0] m_pat_q;
  logic             match_ev;

  assign stamp    = cnt_q;
  assign match_ev = m_armed_q && tick && (pins == m_pat_q);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= time_step(cnt_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_armed_q <= 1'b0;
      m_pat_q   <= '0;
      pm_hit    <= 1'b0;
      pm_time   <= '0;
    end else if (pm_arm) begin
      m_armed_q <= 1'b1;
      m_pat_q   <= pm_pat;
      pm_hit    <= 1'b0;
    end else if (match_ev) begin
      m_armed_q <= 1'b0;
      pm_hit    <= 1'b1;
      pm_time   <= cnt_q;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == ptime_t'($past(cnt_q) + 1'b1)) else $error("cnt step"); // R6
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)) else $error("cnt hold"); // R6
  AST_MATCH_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev && !pm_arm |=> pm_hit && pm_time == $past(cnt_q)) else $error("match stamp"); // R9
  AST_MATCH_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    pm_arm |=> !pm_hit) else $error("match rearm"); // R9
endmodule

// File: rtl/dser_shifter.sv
module dser_shifter
  import dser_pkg::*;
#(
  parameter int PIN_W = 2,
  parameter int BUF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PIN_W-1:0] pins,
  input  logic             clr,
  input  ptime_t           stamp,
  input  logic             at_arm,
  input  ptime_t           at_time,
  output logic             load,
  output logic [BUF_W-1:0] word
);
  localparam int BEATS = beats_per_word(BUF_W, PIN_W);
  localparam int FW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [BUF_W-1:0] sh_q, sh_nx;
  logic [FW-1:0]    fill_q;
  logic             armed_q;
  ptime_t           tgt_q;
  logic             take, last_beat, align_hit;

  generate
    if (BEATS == 1) begin : g_single
      assign sh_nx = pins;
    end else begin : g_multi
      assign sh_nx = {pins, sh_q[BUF_W-1:PIN_W]};
    end
  endgenerate

  assign take      = tick && !clr;
  assign last_beat = (fill_q == FW'(BEATS - 1));
  assign align_hit = armed_q && (stamp == tgt_q);
  assign load      = take && (armed_q ? align_hit : last_beat);
  assign word      = sh_nx;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else if (tick) begin
      sh_q   <= sh_nx;
      fill_q <= (load || last_beat) ? '0 : fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tgt_q   <= '0;
    end else if (at_arm) begin
      armed_q <= 1'b1;
      tgt_q   <= at_time;
    end else if (take && align_hit) begin
      armed_q <= 1'b0;
    end
  end

  AST_FILL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    take && !load && !last_beat |=> fill_q == FW'($past(fill_q) + 1'b1)) else $error("fill"); // R2
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> fill_q == '0 && sh_q == '0) else $error("clr empty"); // R7
  AST_ALIGN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> fill_q == '0) else $error("align restart"); // R8
endmodule

// File: rtl/dser_xfer.sv
module dser_xfer #(
  parameter int BUF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BUF_W-1:0] word,
  input  logic             rd,
  input  logic             clr,
  output logic [BUF_W-1:0] xfer_q,
  output logic             ready_q,
  output logic             ovf_q
);
  logic lost_ev;
  assign lost_ev = load && ready_q && !rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_q  <= '0;
      ready_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (load) xfer_q <= word;
      if (load) ready_q <= 1'b1;
      else if (rd) ready_q <= 1'b0;
      if (clr) ovf_q <= 1'b0;
      else if (lost_ev) ovf_q <= 1'b1;
    end
  end

  AST_READY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ready_q && xfer_q == $past(word)) else $error("ready on load"); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(xfer_q)) else $error("data hold"); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !load |=> !ready_q) else $error("read clears"); // R4
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    lost_ev && !clr |=> ovf_q) else $error("overrun set"); // R5
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ovf_q) else $error("overrun clear"); // R7
endmodule

// File: rtl/dser_port.sv
module dser_port
  import dser_pkg::*;
#(
  parameter int PIN_W = 2,
  parameter int BUF_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PIN_W-1:0]   pins,
  input  logic               rd,
  input  logic               clr_buf,
  input  logic               at_arm,
  input  logic [TIME_W-1:0]  at_time,
  input  logic               pm_arm,
  input  logic [PIN_W-1:0]   pm_pat,
  output logic [BUF_W-1:0]   rd_data,
  output logic               word_rdy,
  output logic               ovf,
  output logic [TIME_W-1:0]  ptime,
  output logic               pm_hit,
  output logic [TIME_W-1:0]  pm_time
);
  ptime_t           stamp;
  logic             load;
  logic [BUF_W-1:0] word;

  dser_timebase #(.PIN_W(PIN_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pins(pins),
    .pm_arm(pm_arm), .pm_pat(pm_pat),
    .stamp(stamp), .pm_hit(pm_hit), .pm_time(pm_time)
  );

  dser_shifter #(.PIN_W(PIN_W), .BUF_W(BUF_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pins(pins), .clr(clr_buf),
    .stamp(stamp), .at_arm(at_arm), .at_time(at_time),
    .load(load), .word(word)
  );

  dser_xfer #(.BUF_W(BUF_W)) u_xf (
    .clk(clk), .rst_n(rst_n), .load(load), .word(word), .rd(rd),
    .clr(clr_buf), .xfer_q(rd_data), .ready_q(word_rdy), .ovf_q(ovf)
  );

  assign ptime = stamp;

  AST_LOAD_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> tick && !clr_buf) else $error("load without tick"); // R7
endmodule

// File: tb/dser_port_test.sv
module dser_port_test;
  localparam int PIN_W = 2;
  localparam int BUF_W = 8;
  localparam int BEATS = BUF_W / PIN_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, rd = 1'b0, clr_buf = 1'b0, at_arm = 1'b0, pm_arm = 1'b0;
  logic [PIN_W-1:0] pins = '0, pm_pat = '0;
  logic [15:0] at_time = '0;
  logic [BUF_W-1:0] rd_data;
  logic word_rdy, ovf, pm_hit;
  logic [15:0] ptime, pm_time;

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [15:0] exp_cnt = '0;

  always #2.5 clk = ~clk;

  dser_port #(.PIN_W(PIN_W), .BUF_W(BUF_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pins(pins), .rd(rd),
    .clr_buf(clr_buf), .at_arm(at_arm), .at_time(at_time),
    .pm_arm(pm_arm), .pm_pat(pm_pat), .rd_data(rd_data),
    .word_rdy(word_rdy), .ovf(ovf), .ptime(ptime),
    .pm_hit(pm_hit), .pm_time(pm_time)
  );

  // samples s0..s3 from MSB pair down, then expected word (s0 in low bits)
  localparam logic [15:0] VEC [4] = '{
    {8'b01_10_11_00, 8'h39},
    {8'b11_11_00_01, 8'h4F},
    {8'b00_01_00_01, 8'h44},
    {8'b10_00_00_11, 8'hC2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one active cycle; outputs checked at the following negedge
  task automatic cyc(input logic t, input logic [PIN_W-1:0] p, input logic r, input logic c);
    tick = t; pins = p; rd = r; clr_buf = c;
    @(negedge clk);
    tick = 1'b0; rd = 1'b0; clr_buf = 1'b0;
    if (t) exp_cnt = exp_cnt + 16'd1;
  endtask

  function automatic logic [BUF_W-1:0] stamp_word(input logic [15:0] last);
    logic [BUF_W-1:0] w;
    w = '0;
    for (int j = 0; j < BEATS; j++) begin
      logic [15:0] s;
      s = last - 16'(BEATS - 1) + 16'(j);
      w[j*PIN_W +: PIN_W] = s[PIN_W-1:0];
    end
    return w;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] tgt, mstamp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdy", word_rdy, 0); chk("R1 ovf", ovf, 0); chk("R1 hit", pm_hit, 0);
    chk("R1 ptime", ptime, 0); chk("R1 data", rd_data, 0);

    // R2/R3/R4 table of words
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < BEATS; k++) begin
        cyc(1'b1, VEC[i][15 - 2*k -: 2], 1'b0, 1'b0);
        if (k == BEATS - 2) chk("R3 no early word", word_rdy, 0);
      end
      chk("R2 ready", word_rdy, 1);
      chk("R2 word", rd_data, VEC[i][7:0]);
      cyc(1'b0, '0, 1'b1, 1'b0);
      chk("R4 read clears", word_rdy, 0);
      chk("R3 data held", rd_data, VEC[i][7:0]);
    end
    chk("R6 count", ptime, exp_cnt);

    // R5 overrun, R4 simultaneous read
    for (int k = 0; k < BEATS; k++) cyc(1'b1, 2'd1, 1'b0, 1'b0);
    for (int k = 0; k < BEATS; k++) cyc(1'b1, 2'd2, 1'b0, 1'b0);
    chk("R5 replaced", rd_data, 8'hAA);
    chk("R5 ovf set", ovf, 1);
    for (int k = 0; k < BEATS - 1; k++) cyc(1'b1, 2'd3, 1'b0, 1'b0);
    cyc(1'b1, 2'd3, 1'b1, 1'b0);
    chk("R4 rd with load rdy", word_rdy, 1);
    chk("R4 rd with load data", rd_data, 8'hFF);
    cyc(1'b0, '0, 1'b1, 1'b0);
    chk("R4 read clears", word_rdy, 0);
    chk("R5 ovf sticky", ovf, 1);

    // R7 clear with a tick in the same cycle
    cyc(1'b1, 2'd3, 1'b0, 1'b0);
    cyc(1'b1, 2'd3, 1'b0, 1'b0);
    cyc(1'b1, 2'd3, 1'b0, 1'b1);
    chk("R7 ovf cleared", ovf, 0);
    chk("R7 ptime still counts", ptime, exp_cnt);
    for (int k = 0; k < BEATS; k++) begin
      cyc(1'b1, 2'(k), 1'b0, 1'b0);
      if (k == BEATS - 2) chk("R7 no word after 3", word_rdy, 0);
    end
    chk("R7 fresh word rdy", word_rdy, 1);
    chk("R7 fresh word", rd_data, 8'hE4);
    cyc(1'b0, '0, 1'b1, 1'b0);

    // R8 timed alignment from a mid-word fill
    cyc(1'b1, exp_cnt[1:0], 1'b0, 1'b0);
    tgt = exp_cnt + 16'd6;
    at_time = tgt; at_arm = 1'b1;
    @(negedge clk);
    at_arm = 1'b0;
    while (exp_cnt != tgt) begin
      cyc(1'b1, exp_cnt[1:0], 1'b0, 1'b0);
      chk("R8 suppressed", word_rdy, 0);
    end
    cyc(1'b1, exp_cnt[1:0], 1'b0, 1'b0);
    chk("R8 aligned rdy", word_rdy, 1);
    chk("R8 aligned word", rd_data, stamp_word(tgt));
    cyc(1'b0, '0, 1'b1, 1'b0);
    for (int k = 0; k < BEATS; k++) begin
      cyc(1'b1, exp_cnt[1:0], 1'b0, 1'b0);
      if (k == BEATS - 2) chk("R8 spacing", word_rdy, 0);
    end
    chk("R8 next rdy", word_rdy, 1);
    chk("R8 next word", rd_data, stamp_word(tgt + 16'(BEATS)));
    cyc(1'b0, '0, 1'b1, 1'b0);

    // R9 pin match stamp
    pm_pat = 2'd3; pm_arm = 1'b1;
    @(negedge clk);
    pm_arm = 1'b0;
    cyc(1'b1, 2'd0, 1'b0, 1'b0);
    cyc(1'b1, 2'd1, 1'b0, 1'b0);
    chk("R9 no hit yet", pm_hit, 0);
    mstamp = exp_cnt;
    cyc(1'b1, 2'd3, 1'b0, 1'b0);
    chk("R9 hit", pm_hit, 1);
    chk("R9 stamp", pm_time, mstamp);
    cyc(1'b1, 2'd3, 1'b0, 1'b0);
    chk("R9 stamp kept", pm_time, mstamp);
    pm_arm = 1'b1;
    @(negedge clk);
    pm_arm = 1'b0;
    chk("R9 rearm clears", pm_hit, 0);

    // R6 hold and wrap
    repeat (3) @(negedge clk);
    chk("R6 hold", ptime, exp_cnt);
    begin
      int n;
      n = 16'hFFFF - exp_cnt;
      tick = 1'b1; pins = '0;
      repeat (n) @(negedge clk);
      tick = 1'b0;
      exp_cnt = 16'hFFFF;
    end
    chk("R6 top", ptime, 16'hFFFF);
    cyc(1'b1, '0, 1'b0, 1'b0);
    chk("R6 wrap", ptime, 16'h0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule